// File: doc/BRIEF.md
# Carrier Loop Mode Sequencer

This controller decides how a carrier tracking loop runs while the loop is first closed and whenever it loses lock. It always starts the loop as a frequency-locked loop at its widest bandwidth, because a phase-locked loop closed with a large frequency error can settle on a false lock. It then narrows the frequency loop one step at a time. After that it hands over to a phase-locked loop that starts wide again to pull in the remaining frequency error. Finally it narrows the phase loop down to its steady-state setting.

The loop filter reads two registered outputs. The first is a mode bit. The second is a bandwidth index within that mode. Two one-cycle strobes mark each cycle in which these outputs take a new value. Progress is paced by an integration-epoch tick. A step is taken only after a run-time dwell count of consecutive ticks during which the lock indicator for the current mode is high. If phase lock drops for several consecutive epochs, the sequencer returns to the wide frequency loop and the whole closure sequence starts again. A start pulse does the same at any time.

Top module: `trk_mode_seq`

## Requirements
- R1: After reset the outputs show frequency mode at bandwidth index 0, and both strobes are low.
- R2: A start pulse in any state, including a cycle that also carries a tick, puts the outputs on the next edge at frequency mode (modePll=0), index 0, with modeUpd and bwUpd both high for that one cycle.
- R3: In frequency mode, the bandwidth index rises by one after dwellEpochs consecutive ticks with freqLock high. A tick with freqLock low restarts the count. A dwellEpochs of 0 acts as 1.
- R4: When the dwell completes at frequency index 3, the outputs move to phase mode (modePll=1) at index 0, with modeUpd and bwUpd both high.
- R5: In phase mode, the index rises by one after dwellEpochs consecutive ticks with phaseLock high. It stops at index 3 and stays there on further locked ticks, with bwUpd low.
- R6: In phase mode, 3 consecutive ticks with phaseLock low return the outputs to frequency mode at index 0, with both strobes high. A tick with phaseLock high in between restarts the loss count.
- R7: Without a tick or a start pulse, the mode and the index hold and both strobes stay low. bwUpd pulses for one cycle on each index or mode update. modeUpd pulses only on a mode change or a start.
- R8: The index encoding is 3 bits. Index 0 is the widest bandwidth and index 3 the narrowest, in each mode.
- R9: phaseLock has no effect in frequency mode, so no fallback occurs there. freqLock has no effect in phase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Loop-closure start, restarts the sequence |
| epochTick | input | 1 | One-cycle integration-epoch tick |
| freqLock | input | 1 | Frequency-lock indicator |
| phaseLock | input | 1 | Phase-lock detector output |
| dwellEpochs | input | DWELL_W (8) | Locked ticks needed per bandwidth step |
| modePll | output | 1 | 0 = frequency loop, 1 = phase loop |
| bwIdx | output | STEP_W (3) | Bandwidth index, 0 = widest |
| modeUpd | output | 1 | One-cycle strobe on mode change or start |
| bwUpd | output | 1 | One-cycle strobe on bandwidth or mode update |

## Verification
The bench builds the block with its default parameters: an 8-bit dwell count, four steps per mode in a 3-bit index, and a three-epoch loss filter. These values keep every transition of the full closure sequence and the fallback within a few dozen ticks. Because the dwell count is a run-time input, one build can cover dwell values of 2, 1 and 0. A dwell of 2 exposes the restart of the count on a missed lock. Dwell values of 1 and 0 let the bench move quickly to the mode boundary and then issue a start pulse from deep in the phase loop.

// File: rtl/trk_mode_pkg.sv
package trk_mode_pkg;
  typedef struct packed {
    logic clrDwell;
    logic incDwell;
    logic clrLoss;
    logic incLoss;
  } cntCmd_t;
endpackage

// File: rtl/trk_mode_cnt.sv
module trk_mode_cnt
  import trk_mode_pkg::*;
#(
  parameter int DWELL_W     = 8,
  parameter int LOSS_EPOCHS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntCmd_t            cmd,
  input  logic [DWELL_W-1:0] dwellEpochs,
  output logic               dwellHit,
  output logic               lossHit
);
  localparam int LOSS_W = $clog2(LOSS_EPOCHS + 1);

  logic [DWELL_W-1:0] dwellCnt;
  logic [LOSS_W-1:0]  lossCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dwellCnt <= '0;
    else if (cmd.clrDwell) dwellCnt <= '0;
    else if (cmd.incDwell) dwellCnt <= dwellCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lossCnt <= '0;
    else if (cmd.clrLoss) lossCnt <= '0;
    else if (cmd.incLoss) lossCnt <= lossCnt + 1'b1;
  end

  // The hit flags look one tick ahead: they are true when the tick now being
  // counted completes the window.
  assign dwellHit = ({1'b0, dwellCnt} + {{DWELL_W{1'b0}}, 1'b1}) >= {1'b0, dwellEpochs};
  assign lossHit  = ({1'b0, lossCnt} + {{LOSS_W{1'b0}}, 1'b1}) >= (LOSS_W + 1)'(LOSS_EPOCHS);
endmodule

// File: rtl/trk_mode_ctrl.sv
module trk_mode_ctrl
  import trk_mode_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int NUM_STEPS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              epochTick,
  input  logic              freqLock,
  input  logic              phaseLock,
  input  logic              dwellHit,
  input  logic              lossHit,
  output cntCmd_t           cmd,
  output logic              modePll,
  output logic [STEP_W-1:0] bwIdx,
  output logic              modeUpd,
  output logic              bwUpd
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic              modeNxt;
  logic [STEP_W-1:0] idxNxt;
  logic              modeUpdNxt;
  logic              bwUpdNxt;
  logic              lockOk;
  logic              atTop;

  assign lockOk = modePll ? phaseLock : freqLock;
  assign atTop  = modePll && (bwIdx == LAST_STEP);

  always_comb begin
    modeNxt    = modePll;
    idxNxt     = bwIdx;
    modeUpdNxt = 1'b0;
    bwUpdNxt   = 1'b0;
    cmd        = '0;
    if (startPulse) begin
      modeNxt      = 1'b0;
      idxNxt       = '0;
      modeUpdNxt   = 1'b1;
      bwUpdNxt     = 1'b1;
      cmd.clrDwell = 1'b1;
      cmd.clrLoss  = 1'b1;
    end else if (epochTick) begin
      // loss filter only runs in the phase loop
      if (modePll && !phaseLock) cmd.incLoss = 1'b1;
      else                       cmd.clrLoss = 1'b1;

      if (modePll && !phaseLock && lossHit) begin
        modeNxt      = 1'b0;
        idxNxt       = '0;
        modeUpdNxt   = 1'b1;
        bwUpdNxt     = 1'b1;
        cmd.clrDwell = 1'b1;
        cmd.clrLoss  = 1'b1;
        cmd.incLoss  = 1'b0;
      end else if (lockOk && !atTop) begin
        if (dwellHit) begin
          cmd.clrDwell = 1'b1;
          bwUpdNxt     = 1'b1;
          if (bwIdx == LAST_STEP) begin
            modeNxt    = 1'b1;
            idxNxt     = '0;
            modeUpdNxt = 1'b1;
          end else begin
            idxNxt = bwIdx + 1'b1;
          end
        end else begin
          cmd.incDwell = 1'b1;
        end
      end else begin
        cmd.clrDwell = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePll <= 1'b0;
      bwIdx   <= '0;
      modeUpd <= 1'b0;
      bwUpd   <= 1'b0;
    end else begin
      modePll <= modeNxt;
      bwIdx   <= idxNxt;
      modeUpd <= modeUpdNxt;
      bwUpd   <= bwUpdNxt;
    end
  end
endmodule

// File: rtl/trk_mode_seq.sv
module trk_mode_seq
  import trk_mode_pkg::*;
#(
  parameter int DWELL_W     = 8,
  parameter int STEP_W      = 3,
  parameter int NUM_STEPS   = 4,
  parameter int LOSS_EPOCHS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               epochTick,
  input  logic               freqLock,
  input  logic               phaseLock,
  input  logic [DWELL_W-1:0] dwellEpochs,
  output logic               modePll,
  output logic [STEP_W-1:0]  bwIdx,
  output logic               modeUpd,
  output logic               bwUpd
);
  cntCmd_t cmd;
  logic    dwellHit;
  logic    lossHit;

  trk_mode_ctrl #(.STEP_W(STEP_W), .NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .epochTick(epochTick),
    .freqLock(freqLock), .phaseLock(phaseLock), .dwellHit(dwellHit),
    .lossHit(lossHit), .cmd(cmd), .modePll(modePll), .bwIdx(bwIdx),
    .modeUpd(modeUpd), .bwUpd(bwUpd)
  );

  trk_mode_cnt #(.DWELL_W(DWELL_W), .LOSS_EPOCHS(LOSS_EPOCHS)) u_cnt (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dwellEpochs(dwellEpochs),
    .dwellHit(dwellHit), .lossHit(lossHit)
  );
endmodule

// File: rtl/trk_mode_chk.sv
module trk_mode_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              epochTick,
  input logic              freqLock,
  input logic              phaseLock,
  input logic              modePll,
  input logic [STEP_W-1:0] bwIdx,
  input logic              modeUpd,
  input logic              bwUpd
);
  AST_START_TO_WIDE_FLL: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!modePll && bwIdx == '0 && modeUpd && bwUpd)); // R2

  AST_ENTER_PLL_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modePll) |-> (bwIdx == '0 && modeUpd && bwUpd)); // R4

  AST_LOCKED_PLL_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (modePll && phaseLock && !startPulse) |=> modePll); // R6

  AST_FALLBACK_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modePll) |-> (bwIdx == '0 && modeUpd && bwUpd)); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !epochTick) |=> ($stable(modePll) && $stable(bwIdx) && !bwUpd && !modeUpd)); // R7

  AST_MODE_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    modeUpd |-> bwUpd); // R7

  AST_FLL_NO_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !modePll && !freqLock) |=> (!modePll && $stable(bwIdx))); // R3

  AST_FLL_IGNORES_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (!startPulse && !modePll) |=> (bwIdx != '0 || !modePll || modeUpd)); // R9
endmodule

bind trk_mode_seq trk_mode_chk #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .epochTick(epochTick),
  .freqLock(freqLock), .phaseLock(phaseLock), .modePll(modePll),
  .bwIdx(bwIdx), .modeUpd(modeUpd), .bwUpd(bwUpd)
);

// File: tb/trk_mode_seq_bench.sv
`timescale 1ns/1ps
module trk_mode_seq_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       epochTick = 1'b0;
  logic       freqLock = 1'b0;
  logic       phaseLock = 1'b0;
  logic [7:0] dwellEpochs = 8'd2;
  logic       modePll;
  logic [2:0] bwIdx;
  logic       modeUpd;
  logic       bwUpd;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trk_mode_seq u_trk_mode_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .epochTick(epochTick),
    .freqLock(freqLock), .phaseLock(phaseLock), .dwellEpochs(dwellEpochs),
    .modePll(modePll), .bwIdx(bwIdx), .modeUpd(modeUpd), .bwUpd(bwUpd)
  );

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nErr++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chkState(input string tag, input int m, input int idx, input int mu, input int bu);
    chk({tag, " mode"}, int'(modePll), m);
    chk({tag, " idx"}, int'(bwIdx), idx);
    chk({tag, " modeUpd"}, int'(modeUpd), mu);
    chk({tag, " bwUpd"}, int'(bwUpd), bu);
  endtask

  // driven at a falling edge; returns at the next falling edge
  task automatic doTick(input logic fl, input logic pl);
    epochTick = 1'b1; freqLock = fl; phaseLock = pl;
    @(posedge clk); @(negedge clk);
    epochTick = 1'b0;
  endtask

  task automatic doStart(input logic withTick);
    startPulse = 1'b1; epochTick = withTick; freqLock = 1'b1;
    @(posedge clk); @(negedge clk);
    startPulse = 1'b0; epochTick = 1'b0;
  endtask

  task automatic tReset;
    chkState("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic tFllSteps;
    dwellEpochs = 8'd2;
    doTick(1, 0); chkState("R3 first tick", 0, 0, 0, 0);
    doTick(1, 0); chkState("R3 step to 1", 0, 1, 0, 1);
    @(negedge clk); chkState("R7 strobe clears", 0, 1, 0, 0);
    doTick(1, 0); doTick(0, 1); chkState("R3 miss", 0, 1, 0, 0);
    doTick(1, 0); chkState("R3 restart count", 0, 1, 0, 0);
    doTick(1, 0); chkState("R3 step to 2", 0, 2, 0, 1);
    doTick(1, 0); doTick(1, 0); doTick(1, 0);
    chkState("R9 no fallback in FLL", 0, 3, 0, 0);
    doTick(1, 0); chkState("R4 handover", 1, 0, 1, 1);
    @(negedge clk); chkState("R7 mode strobe clears", 1, 0, 0, 0);
  endtask

  task automatic tPllSteps;
    doTick(0, 1); doTick(0, 1); chkState("R5 R9 step 1", 1, 1, 0, 1);
    doTick(0, 1); doTick(0, 1); chkState("R5 step 2", 1, 2, 0, 1);
    doTick(0, 1); doTick(0, 1); chkState("R5 R8 narrowest", 1, 3, 0, 1);
    for (int i = 0; i < 4; i++) doTick(0, 1);
    chkState("R5 hold at top", 1, 3, 0, 0);
  endtask

  task automatic tFallback;
    doTick(1, 0); doTick(1, 0); chkState("R6 two losses", 1, 3, 0, 0);
    doTick(1, 1); doTick(1, 0); doTick(1, 0);
    chkState("R6 relock restarts", 1, 3, 0, 0);
    doTick(1, 0); chkState("R6 fallback", 0, 0, 1, 1);
  endtask

  task automatic tStart;
    dwellEpochs = 8'd1;
    doTick(1, 0); chkState("R3 dwell one", 0, 1, 0, 1);
    doStart(0); chkState("R2 start in FLL", 0, 0, 1, 1);
    dwellEpochs = 8'd0;
    doTick(1, 0); chkState("R3 dwell zero", 0, 1, 0, 1);
    doTick(1, 0); doTick(1, 0); doTick(1, 0);
    chkState("R4 fast handover", 1, 0, 1, 1);
    doTick(0, 1); chkState("R5 dwell zero PLL", 1, 1, 0, 1);
    doStart(0); chkState("R2 start in PLL", 0, 0, 1, 1);
    doTick(1, 0); doStart(1); chkState("R2 start with tick", 0, 0, 1, 1);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFllSteps();
    tPllSteps();
    tFallback();
    tStart();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule